// File: doc/BRIEF.md
# Paged 24-bit Bus Address Window

This block lets a host with only a byte-wide expansion port reach a 24-bit external byte address space. The host sees four byte locations. Three of them hold the pieces of the external address and the fourth is a data port. A host access to the data port turns into one strobed access on the external bus, at whatever address the three address bytes currently hold.

The three address bytes can be read back without side effects. The host can therefore bump an address byte in place with a read followed by a write of the value plus one. Interrupt code can also save the current address and restore it later. The address never advances on its own, so every change is an explicit register write.

The top address bit decodes the external space into two halves: a RAM half and an I/O half, each with its own chip select. Host requests use a valid/ready handshake. While an external strobe is in progress the block holds ready low, and a requester must keep its request steady until it sees ready high at a clock edge. Read responses have no back-pressure: `hst_rvalid` is high for exactly one cycle per accepted read, responses come back in request order, and the host must take each one when it appears.

Top module: `xbw_window`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all three address bytes are zero (`ext_addr` = 0), `ext_cs_ram`, `ext_cs_io`, `ext_we`, `ext_oe` and `hst_rvalid` are low, and `hst_rdy` is high.
- R2: An accepted write (`hst_req` and `hst_rdy` high at a clock edge, `hst_wr`=1) with `hst_sel` = 0, 1 or 2 loads `hst_wdata` into address bits [7:0], [15:8] or [23:16] respectively. `ext_addr` shows the new value from the following cycle.
- R3: An accepted read with `hst_sel` = 0, 1 or 2 returns that address byte on `hst_rdata`, with `hst_rvalid` high, in the cycle after acceptance. It changes no address byte and causes no external strobe.
- R4: An accepted write with `hst_sel` = 3 asserts `ext_we` for exactly one cycle, the cycle after acceptance. During that cycle `ext_wdata` equals the host byte and `ext_addr` equals the current address.
- R5: An accepted read with `hst_sel` = 3 asserts `ext_oe` for exactly one cycle, the cycle after acceptance. The block samples `ext_rdata` at the end of that cycle and returns it on `hst_rdata`, with `hst_rvalid` high, in the following cycle.
- R6: `ext_cs_ram` may assert only when `ext_addr[23]`=1, and `ext_cs_io` only when `ext_addr[23]`=0. A chip select is high only together with `ext_we` or `ext_oe`, and never both chip selects together.
- R7: Data-port accesses never change the address. `ext_addr` changes only after an accepted write with `hst_sel` of 0 to 2.
- R8: `hst_rdy` is low in every cycle in which `ext_we` or `ext_oe` is high. A request held through that cycle is accepted at the next edge and is not lost.
- R9: Reading an address byte and writing back the value plus one, modulo 256, leaves that byte incremented and the other two bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host request valid (acts as chip select) |
| hst_rdy | output | 1 | Block can accept a request this cycle |
| hst_sel | input | 2 | Register select: 0..2 address bytes (LSB first), 3 data port |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_wdata | input | 8 | Host write byte |
| hst_rvalid | output | 1 | Read response valid, one cycle |
| hst_rdata | output | 8 | Read response byte |
| ext_addr | output | 24 | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte |
| ext_cs_ram | output | 1 | Chip select, RAM half (bit 23 = 1) |
| ext_cs_io | output | 1 | Chip select, I/O half (bit 23 = 0) |
| ext_we | output | 1 | External write enable |
| ext_oe | output | 1 | External read enable |

## Verification
Two functions can fall in the same cycle here: delivery of a data-port read response and acceptance of the next host request, typically an address-byte write that moves the address the response came from. The bench provokes this by issuing a data-port read and then, with no idle cycle between, an address write. The write is accepted in the very cycle `hst_rvalid` is up. The scoreboard then requires the response to carry the byte from the old location, and requires the following external access to use the new address. Back-to-back register reads after an external write also check that each result is delivered alongside the next acceptance without mixing up the response sources.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
  // Byte width of the host port and of one address slice.
  localparam int unsigned BYTE_W = 8;
  // Number of address slices behind the window.
  localparam int unsigned NSLICE = 3;
  // Width of the external address.
  localparam int unsigned ADDR_W = BYTE_W * NSLICE;
  // Select width: slices plus one data port.
  localparam int unsigned SEL_W  = $clog2(NSLICE + 1);

  // Captured data-port command for the external stage.
  typedef struct packed {
    logic              wr;
    logic [BYTE_W-1:0] data;
  } ext_cmd_t;
endpackage

// File: rtl/xbw_addr_regs.sv
module xbw_addr_regs #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NSLICE = 3,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned ADDR_W = BYTE_W * NSLICE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [BYTE_W-1:0] slice_q [NSLICE];

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slice_q[g] <= '0;
      end else if (wr_en && (sel == SEL_W'(g))) begin
        slice_q[g] <= wdata;
      end
    end
    assign addr[g*BYTE_W +: BYTE_W] = slice_q[g];
  end

  // Side-effect-free read mux; out-of-range select reads zero.
  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NSLICE; i++) begin
      if (sel == SEL_W'(i)) rd_byte = slice_q[i];
    end
  end
endmodule

// File: rtl/xbw_region_decode.sv
module xbw_region_decode #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned RAM_BIT = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output logic              cs_ram,
  output logic              cs_io
);
  logic in_ram;
  assign in_ram = addr[RAM_BIT];
  assign cs_ram = strobe &&  in_ram;
  assign cs_io  = strobe && !in_ram;
endmodule

// File: rtl/xbw_ext_stage.sv
module xbw_ext_stage
  import xbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ext_cmd_t          cmd,
  input  logic [BYTE_W-1:0] ext_rdata,
  output logic              busy,
  output logic              we,
  output logic              oe,
  output logic [BYTE_W-1:0] wdata,
  output logic              rd_done,
  output logic [BYTE_W-1:0] rd_data
);
  logic              live_q;
  ext_cmd_t          cmd_q;
  logic              done_q;
  logic [BYTE_W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cmd_q  <= '0;
      done_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      live_q <= start;
      if (start) cmd_q <= cmd;
      done_q <= live_q && !cmd_q.wr;
      if (live_q && !cmd_q.wr) cap_q <= ext_rdata;
    end
  end

  assign busy    = live_q;
  assign we      = live_q &&  cmd_q.wr;
  assign oe      = live_q && !cmd_q.wr;
  assign wdata   = cmd_q.data;
  assign rd_done = done_q;
  assign rd_data = cap_q;
endmodule

// File: rtl/xbw_window.sv
module xbw_window
  import xbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_req,
  output logic              hst_rdy,
  input  logic [SEL_W-1:0]  hst_sel,
  input  logic              hst_wr,
  input  logic [BYTE_W-1:0] hst_wdata,
  output logic              hst_rvalid,
  output logic [BYTE_W-1:0] hst_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [BYTE_W-1:0] ext_wdata,
  input  logic [BYTE_W-1:0] ext_rdata,
  output logic              ext_cs_ram,
  output logic              ext_cs_io,
  output logic              ext_we,
  output logic              ext_oe
);
  localparam logic [SEL_W-1:0] DATA_SEL = SEL_W'(NSLICE);

  logic              accept, is_data;
  logic              stage_busy, stage_done;
  logic [BYTE_W-1:0] stage_data, slice_byte;
  logic              reg_rv_q;
  logic [BYTE_W-1:0] reg_rd_q;
  ext_cmd_t          cmd;

  assign accept  = hst_req && hst_rdy;
  assign is_data = (hst_sel == DATA_SEL);
  assign hst_rdy = !stage_busy;
  assign cmd     = '{wr: hst_wr, data: hst_wdata};

  xbw_addr_regs #(
    .BYTE_W(BYTE_W), .NSLICE(NSLICE), .SEL_W(SEL_W)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && hst_wr && !is_data),
    .sel     (hst_sel),
    .wdata   (hst_wdata),
    .addr    (ext_addr),
    .rd_byte (slice_byte)
  );

  xbw_ext_stage stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && is_data),
    .cmd       (cmd),
    .ext_rdata (ext_rdata),
    .busy      (stage_busy),
    .we        (ext_we),
    .oe        (ext_oe),
    .wdata     (ext_wdata),
    .rd_done   (stage_done),
    .rd_data   (stage_data)
  );

  xbw_region_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr   (ext_addr),
    .strobe (ext_we || ext_oe),
    .cs_ram (ext_cs_ram),
    .cs_io  (ext_cs_io)
  );

  // Address-byte read response; cannot coincide with a stage response
  // because no request is accepted while the stage is live.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rv_q <= 1'b0;
      reg_rd_q <= '0;
    end else begin
      reg_rv_q <= accept && !hst_wr && !is_data;
      if (accept && !hst_wr && !is_data) reg_rd_q <= slice_byte;
    end
  end

  assign hst_rvalid = reg_rv_q || stage_done;
  assign hst_rdata  = reg_rv_q ? reg_rd_q : stage_data;
endmodule

// File: rtl/xbw_window_chk.sv
module xbw_window_chk
  import xbw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hst_req,
  input logic              hst_rdy,
  input logic [SEL_W-1:0]  hst_sel,
  input logic              hst_wr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_cs_ram,
  input logic              ext_cs_io,
  input logic              ext_we,
  input logic              ext_oe
);
  localparam logic [SEL_W-1:0] DSEL = SEL_W'(NSLICE);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!ext_we && !ext_oe && !ext_cs_ram && !ext_cs_io);
    end
  end

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_cs_ram, ext_cs_io}));

  // R6
  cs_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs_ram || ext_cs_io) |-> (ext_we || ext_oe));

  // R6
  ram_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs_ram |-> ext_addr[ADDR_W-1]);

  // R6
  io_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs_io |-> !ext_addr[ADDR_W-1]);

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |=> !ext_we);

  // R4
  we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> $past(hst_req && hst_rdy && hst_wr && hst_sel == DSEL));

  // R5
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_oe |-> $past(hst_req && hst_rdy && !hst_wr && hst_sel == DSEL));

  // R8
  stage_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we || ext_oe) |-> !hst_rdy);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_req && hst_rdy && hst_wr && hst_sel != DSEL) |=> $stable(ext_addr));
endmodule

bind xbw_window xbw_window_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .hst_req    (hst_req),
  .hst_rdy    (hst_rdy),
  .hst_sel    (hst_sel),
  .hst_wr     (hst_wr),
  .ext_addr   (ext_addr),
  .ext_cs_ram (ext_cs_ram),
  .ext_cs_io  (ext_cs_io),
  .ext_we     (ext_we),
  .ext_oe     (ext_oe)
);

// File: tb/xbw_window_tb_top.sv
module xbw_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0;
  logic        hst_rdy;
  logic [1:0]  hst_sel = '0;
  logic        hst_wr = 1'b0;
  logic [7:0]  hst_wdata = '0;
  logic        hst_rvalid;
  logic [7:0]  hst_rdata;
  logic [23:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata;
  logic        ext_cs_ram, ext_cs_io, ext_we, ext_oe;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  xbw_window dut_i (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_rdy(hst_rdy),
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_wdata(hst_wdata),
    .hst_rvalid(hst_rvalid), .hst_rdata(hst_rdata), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_cs_ram(ext_cs_ram),
    .ext_cs_io(ext_cs_io), .ext_we(ext_we), .ext_oe(ext_oe)
  );

  // External device models: RAM indexed by low byte, I/O returns addr^A5.
  logic [7:0] ram_m [256];
  initial for (int i = 0; i < 256; i++) ram_m[i] = 8'h00;
  always @(posedge clk) if (ext_we && ext_cs_ram) ram_m[ext_addr[7:0]] <= ext_wdata;
  assign ext_rdata = ext_cs_io ? (ext_addr[7:0] ^ 8'hA5) : ram_m[ext_addr[7:0]];

  // Bench shadow state.
  logic [7:0] sh_slice [3];
  logic [7:0] sh_ram [256];
  typedef struct packed { logic wr; logic [23:0] a; logic [7:0] d; } ext_ev_t;
  logic [7:0] rsp_q [$];
  ext_ev_t    ev_q  [$];
  logic       prev_we = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] sh_addr();
    return {sh_slice[2], sh_slice[1], sh_slice[0]};
  endfunction

  // Driver: called at a falling edge; returns at the falling edge after acceptance.
  task automatic acc(input logic [1:0] s, input logic w, input logic [7:0] d);
    logic [23:0] a;
    hst_req = 1'b1; hst_sel = s; hst_wr = w; hst_wdata = d;
    while (!hst_rdy) @(negedge clk);
    if (s < 2'd3) begin
      if (w) sh_slice[s] = d;
      else   rsp_q.push_back(sh_slice[s]);
    end else begin
      a = sh_addr();
      ev_q.push_back('{wr: w, a: a, d: d});
      if (w) begin
        if (a[23]) sh_ram[a[7:0]] = d;
      end else begin
        rsp_q.push_back(a[23] ? sh_ram[a[7:0]] : (a[7:0] ^ 8'hA5));
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    hst_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: scoreboard pops.
  always @(negedge clk) begin
    if (rst_n) begin
      if (hst_rvalid) begin
        if (rsp_q.size() == 0) chk(0, "R3", "unexpected response", {24'h0, hst_rdata}, 0);
        else begin
          logic [7:0] e;
          e = rsp_q.pop_front();
          chk(hst_rdata == e, "R3/R5", "read response", {24'h0, hst_rdata}, {24'h0, e});
        end
      end
      if (ext_we || ext_oe) begin
        chk(!hst_rdy, "R8", "ready during strobe", {31'h0, hst_rdy}, 0);
        chk(ext_cs_ram == ext_addr[23] && ext_cs_io == !ext_addr[23], "R6",
            "region select", {30'h0, ext_cs_ram, ext_cs_io},
            {30'h0, ext_addr[23], !ext_addr[23]});
        if (ev_q.size() == 0) chk(0, "R3", "unexpected strobe", {8'h0, ext_addr}, 0);
        else begin
          ext_ev_t e;
          e = ev_q.pop_front();
          chk(ext_we == e.wr && ext_oe == !e.wr, "R4/R5", "strobe kind",
              {30'h0, ext_we, ext_oe}, {30'h0, e.wr, !e.wr});
          chk(ext_addr == e.a, "R7", "strobe address", {8'h0, ext_addr}, {8'h0, e.a});
          if (e.wr) chk(ext_wdata == e.d, "R4", "write byte", {24'h0, ext_wdata}, {24'h0, e.d});
        end
      end
      if (prev_we && ext_we) chk(0, "R4", "write enable longer than one cycle", 1, 0);
      prev_we = ext_we;
    end
  end

  task automatic check_addr(input string req);
    chk(ext_addr == sh_addr(), req, "ext_addr", {8'h0, ext_addr}, {8'h0, sh_addr()});
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 3; i++) sh_slice[i] = 8'h00;
    for (int i = 0; i < 256; i++) sh_ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ext_addr == 24'h0, "R1", "addr in reset", {8'h0, ext_addr}, 0);
    chk(!ext_we && !ext_oe && !ext_cs_ram && !ext_cs_io, "R1", "strobes in reset",
        {28'h0, ext_we, ext_oe, ext_cs_ram, ext_cs_io}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hst_rdy && !hst_rvalid, "R1", "ready/rvalid after reset",
        {30'h0, hst_rdy, hst_rvalid}, 32'h2);

    // R2: build address 0x801234 (RAM half)
    acc(2'd0, 1'b1, 8'h34); check_addr("R2");
    acc(2'd1, 1'b1, 8'h12); check_addr("R2");
    acc(2'd2, 1'b1, 8'h80); check_addr("R2");
    // R3: back-to-back read-back, no strobes expected
    acc(2'd0, 1'b0, 8'h00);
    acc(2'd1, 1'b0, 8'h00);
    acc(2'd2, 1'b0, 8'h00);
    idle(2); check_addr("R3");

    // R4, R5, R8: data write then held read (back-pressure)
    acc(2'd3, 1'b1, 8'h5A);
    acc(2'd3, 1'b0, 8'h00);
    idle(3); check_addr("R7");
    // R7: address bytes unchanged after data accesses
    acc(2'd0, 1'b0, 8'h00);
    acc(2'd2, 1'b0, 8'h00);

    // several RAM locations
    for (int k = 0; k < 4; k++) begin
      acc(2'd0, 1'b1, 8'(8'h40 + k));
      acc(2'd3, 1'b1, 8'(8'hC0 ^ (k * 8'h13)));
    end
    for (int k = 0; k < 4; k++) begin
      acc(2'd0, 1'b1, 8'(8'h40 + k));
      acc(2'd3, 1'b0, 8'h00);
    end

    // R6: I/O half, write must not land in RAM
    acc(2'd0, 1'b1, 8'h34);
    acc(2'd2, 1'b1, 8'h00); check_addr("R6");
    acc(2'd3, 1'b0, 8'h00);
    acc(2'd3, 1'b1, 8'hEE);
    acc(2'd2, 1'b1, 8'h80);
    acc(2'd3, 1'b0, 8'h00);  // expects 0x5A still

    // R9: read-modify-write increment with wrap
    acc(2'd0, 1'b1, 8'hFF);
    acc(2'd0, 1'b0, 8'h00);
    idle(2);
    acc(2'd0, 1'b1, 8'(sh_slice[0] + 8'd1));
    acc(2'd0, 1'b0, 8'h00);
    acc(2'd1, 1'b0, 8'h00);
    idle(2);
    chk(ext_addr == 24'h801200, "R9", "incremented address", {8'h0, ext_addr}, 32'h801200);

    // Same cycle: data read response delivered while next address write accepted
    acc(2'd0, 1'b1, 8'h41);
    acc(2'd3, 1'b0, 8'h00);
    acc(2'd0, 1'b1, 8'h42);
    check_addr("R2");
    acc(2'd3, 1'b0, 8'h00);
    idle(4);

    chk(rsp_q.size() == 0, "R5", "responses outstanding", rsp_q.size(), 0);
    chk(ev_q.size() == 0, "R4", "strobes outstanding", ev_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule